// File: doc/BRIEF.md
# Selectable Fixed-Polynomial Reducer for Binary Fields

This block reduces a carry-less product modulo one of three fixed irreducible polynomials. The supported binary extension fields have degrees 163, 233 and 283. It sits after a wide polynomial multiplier in an elliptic-curve datapath. The multiplier is sized for the largest field and smaller operands are zero-padded. The reducer brings the double-width product back down to a field element of the chosen degree.

Three reduction networks run side by side, one per field, and each is built only from fixed XOR wiring. The upper part of the product stands for a multiple of x^m. Since x^m is congruent to the low-order terms of the polynomial, each network folds the upper part onto the lower part by XORing shifted copies of it. The fold adds a few new bits above m, so the network folds those bits once more. Two folds are always enough, because the second-highest term of each polynomial lies below m/2.

A two-bit field select picks which network's result is captured. The output register is cleared by a synchronous active-high reset, which gives the block a latency of one clock.

Top module: `gf2m_multi_reducer`

## Requirements
- R1: While `rst` is high at a rising edge, `rem_o` becomes all zeros at that edge.
- R2: With `fsel_i` = 0, `rem_o` is the product modulo x^163 + x^7 + x^6 + x^3 + 1.
- R3: With `fsel_i` = 1, `rem_o` is the product modulo x^233 + x^74 + 1.
- R4: With `fsel_i` = 2, `rem_o` is the product modulo x^283 + x^12 + x^7 + x^5 + 1.
- R5: With `fsel_i` = 3, `rem_o` is all zeros whatever the product is.
- R6: For a selected field of degree m, bits m through 282 of `rem_o` are zero.
- R7: For a selected field of degree m, product bits above bit 2m−2 have no effect on `rem_o`.
- R8: A product with no bit set at or above position 163 appears unchanged on `rem_o` for field codes 0, 1 and 2.
- R9: `rem_o` reflects the `prod_i` and `fsel_i` values sampled at the previous rising edge, and inputs may change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| prod_i | input | 565 | Carry-less product; bit i is the coefficient of x^i |
| fsel_i | input | 2 | Field select: 0 = degree 163, 1 = degree 233, 2 = degree 283, 3 = none |
| rem_o | output | 283 | Reduced remainder, zero above the selected degree, registered |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the cleared output after reset, the zero result for the unused select code, the zero bits above the degree for the two smaller fields, the unchanged pass-through of already-reduced products, and a steady output under steady inputs. Each network also asserts, in its own logic, that its folds leave an input with an empty upper part unchanged. The actual remainder values can only be shown by the bench scenarios. Those runs compare every cycle against a bit-serial long division for each polynomial. They cover empty, single-top-bit, all-ones and random products, and products with garbage above 2m−2.

// File: rtl/gf2m_red_pkg.sv
package gf2m_red_pkg;

    localparam int MAX_M   = 283;
    localparam int PROD_W  = 2 * MAX_M - 1;
    localparam int NUM_FLD = 3;

    typedef enum logic [1:0] {
        FLD_163  = 2'd0,
        FLD_233  = 2'd1,
        FLD_283  = 2'd2,
        FLD_NONE = 2'd3
    } fld_sel_e;

    typedef logic [MAX_M-1:0]  rem_t;
    typedef logic [PROD_W-1:0] prod_t;

    typedef struct packed {
        rem_t r283;
        rem_t r233;
        rem_t r163;
    } net_bus_t;

    // Field degree per network index
    function automatic int fld_deg(input int idx);
        case (idx)
            0:       return 163;
            1:       return 233;
            default: return 283;
        endcase
    endfunction

    // Highest low-order term of r(x) - x^m
    function automatic int fld_tap_hi(input int idx);
        case (idx)
            0:       return 7;
            1:       return 74;
            default: return 12;
        endcase
    endfunction

    function automatic int fld_tap_mid(input int idx);
        case (idx)
            0:       return 6;
            1:       return 0;
            default: return 7;
        endcase
    endfunction

    function automatic int fld_tap_lo(input int idx);
        case (idx)
            0:       return 3;
            1:       return 0;
            default: return 5;
        endcase
    endfunction

    // Five-term polynomial (1) or three-term (0)
    function automatic bit fld_is_penta(input int idx);
        return idx != 1;
    endfunction

endpackage

// File: rtl/gf2m_fold_net.sv
module gf2m_fold_net #(
    parameter int M       = 163,
    parameter int TAP_HI  = 7,
    parameter int TAP_MID = 6,
    parameter int TAP_LO  = 3,
    parameter bit PENTA   = 1'b1,
    parameter int OUT_W   = 283
) (
    input  logic [2*M-2:0]  prod_i,
    output logic [OUT_W-1:0] rem_o
);

    localparam int W1 = M + TAP_HI - 1;   // width after first fold
    localparam int HW = TAP_HI - 1;       // overflow width after first fold

    logic [M-1:0]  c0;
    logic [M-2:0]  c1;
    logic [W1-1:0] c0x;
    logic [W1-1:0] c1x;
    logic [W1-1:0] s1;
    logic [HW-1:0] ov;
    logic [M-1:0]  ovx;
    logic [M-1:0]  s2;

    assign c0  = prod_i[M-1:0];
    assign c1  = prod_i[2*M-2:M];
    assign c0x = W1'(c0);
    assign c1x = W1'(c1);
    assign ov  = s1[W1-1:M];
    assign ovx = M'(ov);

    generate
        if (PENTA) begin : g_penta
            assign s1 = c0x ^ c1x ^ (c1x << TAP_HI) ^ (c1x << TAP_MID) ^ (c1x << TAP_LO);
            assign s2 = s1[M-1:0] ^ ovx ^ (ovx << TAP_HI) ^ (ovx << TAP_MID) ^ (ovx << TAP_LO);
        end else begin : g_tri
            assign s1 = c0x ^ c1x ^ (c1x << TAP_HI);
            assign s2 = s1[M-1:0] ^ ovx ^ (ovx << TAP_HI);
        end
    endgenerate

    assign rem_o = OUT_W'(s2);

    // An already reduced input must survive both folds untouched
    always_comb begin
        if (!$isunknown(prod_i) && (c1 == '0)) begin
            AST_FOLD_IDENTITY: assert (s2 == c0); // R8
        end
    end

endmodule

// File: rtl/gf2m_red_sel.sv
module gf2m_red_sel
    import gf2m_red_pkg::*;
(
    input  net_bus_t nets_i,
    input  fld_sel_e sel_i,
    output rem_t     rem_o
);

    always_comb begin
        case (sel_i)
            FLD_163: rem_o = nets_i.r163;
            FLD_233: rem_o = nets_i.r233;
            FLD_283: rem_o = nets_i.r283;
            default: rem_o = '0;
        endcase
    end

endmodule

// File: rtl/gf2m_multi_reducer.sv
module gf2m_multi_reducer
    import gf2m_red_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PROD_W-1:0] prod_i,
    input  logic [1:0]        fsel_i,
    output logic [MAX_M-1:0]  rem_o
);

    rem_t     net_out [NUM_FLD];
    net_bus_t nets;
    rem_t     sel_out;
    rem_t     rem_q;
    fld_sel_e fsel;

    assign fsel = fld_sel_e'(fsel_i);

    generate
        for (genvar g = 0; g < NUM_FLD; g++) begin : g_net
            localparam int GM = fld_deg(g);
            gf2m_fold_net #(
                .M       (GM),
                .TAP_HI  (fld_tap_hi(g)),
                .TAP_MID (fld_tap_mid(g)),
                .TAP_LO  (fld_tap_lo(g)),
                .PENTA   (fld_is_penta(g)),
                .OUT_W   (MAX_M)
            ) u_net (
                .prod_i (prod_i[2*GM-2:0]),
                .rem_o  (net_out[g])
            );
        end
    endgenerate

    assign nets.r163 = net_out[0];
    assign nets.r233 = net_out[1];
    assign nets.r283 = net_out[2];

    gf2m_red_sel u_sel (
        .nets_i (nets),
        .sel_i  (fsel),
        .rem_o  (sel_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else begin
            rem_q <= sel_out;
        end
    end

    assign rem_o = rem_q;

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (rem_o == '0)); // R1

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(fsel_i) == 2'd3) |-> (rem_o == '0)); // R5

    AST_HIGH_ZERO_163: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(fsel_i) == 2'd0) |-> (rem_o[MAX_M-1:163] == '0)); // R6

    AST_HIGH_ZERO_233: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(fsel_i) == 2'd1) |-> (rem_o[MAX_M-1:233] == '0)); // R6

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(fsel_i) != 2'd3 && $past(prod_i[PROD_W-1:163]) == '0)
        |-> (rem_o == $past(prod_i[MAX_M-1:0]))); // R8

    AST_STEADY_OUT: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $stable(prod_i) && $stable(fsel_i)) |=> $stable(rem_o)); // R9

endmodule

// File: tb/tb_gf2m_multi_reducer.sv
`timescale 1ns/1ps
module tb_gf2m_multi_reducer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [564:0] prod_i = '0;
    logic [1:0]   fsel_i = 2'd0;
    logic [282:0] rem_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gf2m_multi_reducer dut (
        .clk    (clk),
        .rst    (rst),
        .prod_i (prod_i),
        .fsel_i (fsel_i),
        .rem_o  (rem_o)
    );

    function automatic int deg_for(input logic [1:0] s);
        case (s)
            2'd0:    return 163;
            2'd1:    return 233;
            default: return 283;
        endcase
    endfunction

    // Bit-serial long division by the chosen polynomial
    function automatic logic [282:0] ref_rem(input logic [564:0] p, input logic [1:0] s);
        logic [283:0] r;
        logic [564:0] w;
        int m;
        if (s == 2'd3) return '0;
        r = '0;
        case (s)
            2'd0: begin r[163] = 1; r[7] = 1; r[6] = 1; r[3] = 1; r[0] = 1; end
            2'd1: begin r[233] = 1; r[74] = 1; r[0] = 1; end
            default: begin r[283] = 1; r[12] = 1; r[7] = 1; r[5] = 1; r[0] = 1; end
        endcase
        m = deg_for(s);
        w = p;
        for (int i = 564; i > 2*m-2; i--) w[i] = 1'b0;
        for (int i = 2*m-2; i >= m; i--)
            if (w[i]) w = w ^ ({281'b0, r} << (i - m));
        return w[282:0];
    endfunction

    function automatic logic [564:0] rnd_prod();
        logic [564:0] v;
        for (int i = 0; i < 565; i++) v[i] = 1'($urandom);
        return v;
    endfunction

    function automatic logic [564:0] mask_prod(input logic [564:0] p, input int lim);
        logic [564:0] v;
        v = p;
        for (int i = 564; i > lim; i--) v[i] = 1'b0;
        return v;
    endfunction

    task automatic check(input string tag, input logic [282:0] act, input logic [282:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, capture on the edge, compare just after
    task automatic step(input string tag, input logic [564:0] p, input logic [1:0] s);
        logic [282:0] exp;
        @(negedge clk);
        prod_i = p;
        fsel_i = s;
        exp = ref_rem(p, s);
        @(posedge clk);
        #1;
        check(tag, rem_o, exp);
    endtask

    task automatic upper_zero(input string tag, input logic [1:0] s);
        int m;
        logic [282:0] hi;
        m = deg_for(s);
        hi = rem_o;
        for (int i = 0; i < m && i < 283; i++) hi[i] = 1'b0;
        check(tag, hi, '0);
    endtask

    initial begin
        logic [564:0] p;
        logic [282:0] r_clean;
        string tags [3];
        tags[0] = "R2";
        tags[1] = "R3";
        tags[2] = "R4";

        // Reset with garbage on the inputs: R1
        prod_i = rnd_prod();
        fsel_i = 2'd2;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", rem_o, '0);
        @(negedge clk);
        rst = 1'b0;

        for (int s = 0; s < 3; s++) begin
            int m;
            m = deg_for(2'(s));
            step(tags[s], '0, 2'(s));
            p = '0;
            p[2*m-2] = 1'b1;
            step(tags[s], p, 2'(s));
            step(tags[s], mask_prod({565{1'b1}}, 2*m-2), 2'(s));
            upper_zero("R6 all-ones", 2'(s));
            p = '0;
            p[m] = 1'b1;
            step(tags[s], p, 2'(s));
            for (int k = 0; k < 12; k++) begin
                step(tags[s], mask_prod(rnd_prod(), 2*m-2), 2'(s));
                upper_zero("R6 random", 2'(s));
            end
            // R7: garbage above 2m-2 must not change the result
            for (int k = 0; k < 4; k++) begin
                p = rnd_prod();
                step("R7 clean", mask_prod(p, 2*m-2), 2'(s));
                r_clean = rem_o;
                @(negedge clk);
                prod_i = p;
                @(posedge clk);
                #1;
                check("R7 garbage", rem_o, r_clean);
            end
            // R8: already reduced product passes through
            p = mask_prod(rnd_prod(), 162);
            step("R8", p, 2'(s));
            check("R8 direct", rem_o, p[282:0]);
        end

        // R5: unused code gives zero
        for (int k = 0; k < 4; k++) begin
            step("R5", rnd_prod(), 2'd3);
            check("R5 direct", rem_o, '0);
        end

        // R9: select and product change every cycle
        for (int k = 0; k < 30; k++)
            step("R9 back-to-back", rnd_prod(), 2'(k % 4));

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        prod_i = rnd_prod();
        fsel_i = 2'd0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", rem_o, '0);
        @(negedge clk);
        rst = 1'b0;
        step("R2 after reset", rnd_prod(), 2'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule